// File: doc/BRIEF.md
# Encoded Interrupt Level Decoder

This block takes a binary-encoded external interrupt level and turns it into one request line in a chain of interrupt sources. A level of zero means that nothing is requested. Nonzero levels rise in priority from 1 (lowest) to the all-ones value (highest). The chain is ordered so that the highest level drives the first source. The source position is the level with every bit inverted, so level 15 selects source 0 and level 1 selects source 14.

At most one chain source is asserted at any time. When the level changes, the new source is asserted and the old one is released on the same clock edge. A downstream enable counter may not yet credit the selected source. In that case the block sends a one-cycle enable-increment strobe for that source in the same cycle that its assert line rises. The strobe is sent once per selection: a level that is held does not repeat the strobe. Vector lookup and priority masking belong to the logic that consumes these lines.

Top module: `irl_level_decoder`

## Requirements
- R1: While reset is low, every assert line and every strobe is 0.
- R2: On the first rising clock edge after reset is released, the outputs stay all zero whatever the level is. Input is sampled from the second edge on.
- R3: A sampled level of 0 drives every assert line to 0 one edge later.
- R4: A sampled nonzero level L asserts exactly line index (L XOR all-ones) one edge later. With the default 4-bit width, level 15 selects bit 0 and level 1 selects bit 14.
- R5: When the level moves to a different nonzero value, the previous line drops on the same edge that the new line rises.
- R6: Take a line that rises while its bit of `src_en_present` (sampled on that edge) is 0. Its bit of `src_en_inc` is 1 for exactly that cycle.
- R7: A line that rises while its bit of `src_en_present` is 1 produces no strobe.
- R8: A held nonzero level keeps its line asserted and produces no further strobe, even if its enable bit stays 0.
- R9: At most one assert line is high, and a strobe appears only on a line that is asserted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| irl_level | input | LVL_W | Encoded interrupt level, 0 = idle |
| src_en_present | input | N_SRC | Per source: 1 if the downstream enable counter already credits it |
| src_assert | output | N_SRC | Per-source request lines (N_SRC = 2^LVL_W - 1) |
| src_en_inc | output | N_SRC | One-cycle enable-increment strobes |

## Verification
The bench builds the block with its default LVL_W of 4, which gives a chain of 15 sources. With this width, every level from 0 to 15 can be driven. That covers both ends of the chain and the idle code, whose inverted index lands one past the last source. The test also covers held levels, jumps between distant levels, and enable masks that credit only some sources, so both the strobed and the silent paths for the same line are exercised.

// File: rtl/irl_dec_pkg.sv
package irl_dec_pkg;

    // Operating phase: the first edge after reset only arms the block.
    typedef enum logic {
        PH_ARM = 1'b0,
        PH_RUN = 1'b1
    } phase_e;

    // Number of chained sources reachable from a level of the given width.
    function automatic int unsigned chain_len(input int unsigned lvl_w);
        return (1 << lvl_w) - 1;
    endfunction

endpackage

// File: rtl/irl_index_decode.sv
module irl_index_decode #(
    parameter int unsigned LVL_W = 4,
    parameter int unsigned N_SRC = 15
) (
    input  logic [LVL_W-1:0] level,
    output logic [N_SRC-1:0] sel
);
    localparam logic [LVL_W-1:0] ALL_ONES = '1;

    logic [LVL_W-1:0] pos;

    // Inverting the level puts the highest priority at chain position 0.
    // Level 0 inverts to N_SRC, which matches no bit below.
    always_comb pos = level ^ ALL_ONES;

    for (genvar i = 0; i < N_SRC; i++) begin : g_bit
        assign sel[i] = (pos == LVL_W'(i));
    end
endmodule

// File: rtl/irl_strobe_gen.sv
module irl_strobe_gen #(
    parameter int unsigned N_SRC = 15
) (
    input  logic             live,
    input  logic [N_SRC-1:0] sel,
    input  logic [N_SRC-1:0] held,
    input  logic [N_SRC-1:0] en_present,
    output logic [N_SRC-1:0] inc
);
    // A strobe fires only for a newly selected line that lacks its enable credit.
    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        assign inc[i] = live & sel[i] & ~held[i] & ~en_present[i];
    end
endmodule

// File: rtl/irl_level_decoder.sv
module irl_level_decoder
    import irl_dec_pkg::*;
#(
    parameter  int unsigned LVL_W = 4,
    localparam int unsigned N_SRC = (1 << LVL_W) - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] irl_level,
    input  logic [N_SRC-1:0] src_en_present,
    output logic [N_SRC-1:0] src_assert,
    output logic [N_SRC-1:0] src_en_inc
);
    typedef struct packed {
        phase_e           phase;
        logic [N_SRC-1:0] lines;
        logic [N_SRC-1:0] strobe;
    } dec_state_t;

    dec_state_t st_d, st_q;
    logic [N_SRC-1:0] sel_w;
    logic [N_SRC-1:0] inc_w;
    logic             live_w;

    irl_index_decode #(
        .LVL_W(LVL_W),
        .N_SRC(chain_len(LVL_W))
    ) u_decode (
        .level(irl_level),
        .sel  (sel_w)
    );

    assign live_w = (st_q.phase == PH_RUN);

    irl_strobe_gen #(
        .N_SRC(N_SRC)
    ) u_strobe (
        .live      (live_w),
        .sel       (sel_w),
        .held      (st_q.lines),
        .en_present(src_en_present),
        .inc       (inc_w)
    );

    always_comb begin
        st_d        = st_q;
        st_d.phase  = PH_RUN;
        st_d.lines  = live_w ? sel_w : '0;
        st_d.strobe = inc_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase  <= PH_ARM;
            st_q.lines  <= '0;
            st_q.strobe <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign src_assert = st_q.lines;
    assign src_en_inc = st_q.strobe;
endmodule

// File: rtl/irl_level_decoder_chk.sv
module irl_level_decoder_chk #(
    parameter int unsigned LVL_W = 4,
    parameter int unsigned N_SRC = 15
) (
    input logic             clk,
    input logic             rst_n,
    input logic [LVL_W-1:0] irl_level,
    input logic [N_SRC-1:0] src_en_present,
    input logic [N_SRC-1:0] src_assert,
    input logic [N_SRC-1:0] src_en_inc
);
    // R9: never more than one request line
    p_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(src_assert));

    // R9: a strobe only accompanies an asserted line
    p_strobe_on_line_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (src_en_inc & ~src_assert) == '0);

    // R3: idle level clears all lines one edge later
    p_idle_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (irl_level == '0) |=> (src_assert == '0));

    // R8: no strobe for a line that was already asserted
    p_no_repeat_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (src_assert != '0) |=> ((src_en_inc & $past(src_assert)) == '0));

    // R7: no strobe for a line whose enable credit was present when sampled
    p_credit_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (src_en_present == '1) |=> (src_en_inc == '0));
endmodule

bind irl_level_decoder irl_level_decoder_chk #(
    .LVL_W(LVL_W),
    .N_SRC(N_SRC)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .irl_level     (irl_level),
    .src_en_present(src_en_present),
    .src_assert    (src_assert),
    .src_en_inc    (src_en_inc)
);

// File: tb/irl_level_decoder_test.sv
module irl_level_decoder_test;
    localparam int CLK_PERIOD = 10;
    localparam int LW = 4;
    localparam int NS = 15;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [LW-1:0] irl_level = '0;
    logic [NS-1:0] src_en_present = '0;
    logic [NS-1:0] src_assert;
    logic [NS-1:0] src_en_inc;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [NS-1:0] a;
        logic [NS-1:0] i;
        string         tag;
    } exp_t;

    exp_t sb[$];

    logic          m_live = 1'b0;
    logic [NS-1:0] m_prev = '0;

    irl_level_decoder #(.LVL_W(LW)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .irl_level     (irl_level),
        .src_en_present(src_en_present),
        .src_assert    (src_assert),
        .src_en_inc    (src_en_inc)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Driver: apply inputs, predict the outputs after the next edge, queue them.
    task automatic step(input logic [LW-1:0] lv, input logic [NS-1:0] en, input string tag);
        exp_t e;
        irl_level      = lv;
        src_en_present = en;
        if (!m_live) begin
            e.a = '0;
            e.i = '0;
        end else begin
            e.a = (lv == 0) ? '0 : (NS'(1) << (lv ^ 4'hF));
            e.i = e.a & ~m_prev & ~en;
        end
        e.tag  = tag;
        m_prev = e.a;
        m_live = 1'b1;
        sb.push_back(e);
        @(negedge clk);
    endtask

    // Monitor: sample a quarter period after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (src_assert !== e.a || src_en_inc !== e.i) begin
                    errors++;
                    $display("FAIL %s: assert=%h exp=%h inc=%h exp=%h",
                             e.tag, src_assert, e.a, src_en_inc, e.i);
                end
                checks++;
                if ($countones(src_assert) > 1) begin
                    errors++;
                    $display("FAIL R9: assert=%h exp=at most one bit", src_assert);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        irl_level = 4'd9;
        repeat (3) @(negedge clk);
        checks++;
        if (src_assert !== '0 || src_en_inc !== '0) begin
            errors++;
            $display("FAIL R1: assert=%h inc=%h exp=0 0", src_assert, src_en_inc);
        end
        rst_n = 1'b1;
        step(4'd15, '0, "R2");              // arming edge: nothing shows
        step(4'd15, '1, "R4");              // bit 0, credit present -> R7 no strobe
        step(4'd15, '1, "R8");              // held
        step(4'd1,  '0, "R5");              // bit 14 rises, bit 0 drops, R6 strobe
        step(4'd1,  '0, "R8");              // held, no repeat strobe
        step(4'd0,  '0, "R3");              // idle
        step(4'd1,  15'h3FFF, "R6");        // bit 14 lacks credit -> strobe
        step(4'd1,  '1, "R8");
        step(4'd8,  15'h7FFF, "R7");        // bit 7 credited
        for (int lv = 1; lv <= 15; lv++) begin
            step(LW'(lv), (lv % 2 == 0) ? '1 : '0, "R4");
        end
        step(4'd15, '0, "R8");
        step(4'd0,  '1, "R3");
        step(4'd0,  '0, "R3");
        step(4'd3,  '0, "R6");
        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule